// File: doc/BRIEF.md
# Lane Bifurcation Steering Unit

This block sits between sixteen physical lane datapaths and the logical lanes of the link layers above them. Each lane carries a symbol and a valid bit in both directions. By default all sixteen physical lanes serve one x16 primary port. When the block is bifurcated, the lanes split into two x8 ports. The lower eight physical lanes stay with the primary port. The upper eight serve a secondary port, where physical lane 8+j becomes secondary lane j.

Lane reversal applies only to the primary port, and it follows the width that port has. The secondary mapping never reverses. The bifurcation choice is taken while the lanes are held in reset and stays fixed until the next reset. A registered presence flag tells the configuration logic whether the secondary port's function may be found during enumeration.

Top module: `lane_bifurc_steer`

## Requirements
- R1: While `rst_n` is low, `bifurc_mode` takes the value of `bifurc_req` at each rising clock edge. While `rst_n` is high, `bifurc_mode` holds its value, whatever `bifurc_req` does.
- R2: With `bifurc_mode`=0 and `rev_en`=0, primary logical lane i maps to physical lane i in both directions for all 16 lanes. A primary port trained narrower uses only its low lanes and works unchanged.
- R3: With `bifurc_mode`=0 and `rev_en`=1, primary logical lane i maps to physical lane 15-i in both directions.
- R4: With `bifurc_mode`=1, physical lane 8+j maps to secondary lane j in both directions for j in 0..7, whatever the value of `rev_en`.
- R5: With `bifurc_mode`=1, primary logical lane i (i in 0..7) maps to physical lane i when `rev_en`=0, and to physical lane 7-i when `rev_en`=1.
- R6: With `bifurc_mode`=0, every secondary receive lane outputs the idle symbol 8'h00 with valid low, and `sec_tx_*` has no effect on any physical output.
- R7: With `bifurc_mode`=1, primary receive logical lanes 8..15 output the idle symbol 8'h00 with valid low, and primary transmit lanes 8..15 have no effect on any physical output.
- R8: `sec_present` is 0 during reset and whenever `bifurc_mode` is 0. From the first rising edge after reset release it equals `bifurc_mode`, and it does not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low lane reset; the mode is sampled while it is low |
| bifurc_req | input | 1 | Requested split: 1 gives two x8 ports, 0 gives one x16 port |
| rev_en | input | 1 | Primary port lane reversal |
| phy_rx_sym | input | 128 | Receive symbols from physical lanes, lane n at [8n+7:8n] |
| phy_rx_vld | input | 16 | Receive valid bits, one per physical lane |
| pri_tx_sym | input | 128 | Transmit symbols from primary logical lanes |
| pri_tx_vld | input | 16 | Transmit valid bits from primary logical lanes |
| sec_tx_sym | input | 64 | Transmit symbols from secondary logical lanes |
| sec_tx_vld | input | 8 | Transmit valid bits from secondary logical lanes |
| pri_rx_sym | output | 128 | Receive symbols to primary logical lanes |
| pri_rx_vld | output | 16 | Receive valid bits to primary logical lanes |
| sec_rx_sym | output | 64 | Receive symbols to secondary logical lanes |
| sec_rx_vld | output | 8 | Receive valid bits to secondary logical lanes |
| phy_tx_sym | output | 128 | Transmit symbols to physical lanes |
| phy_tx_vld | output | 16 | Transmit valid bits to physical lanes |
| bifurc_mode | output | 1 | Mode latched during reset |
| sec_present | output | 1 | Secondary configuration function visible for enumeration |

## Verification
The hardest case to reach is a change of `bifurc_req` while the lanes are running. It must have no effect, yet it must take effect at the next reset. The bench toggles the request in the middle of every operating phase. It then resets with the opposite value and confirms that the new mode and `sec_present` follow. It also runs a window in which only the low four primary lanes carry valid data, which models a narrow link.

// File: rtl/lane_bifurc_steer.sv
module lane_bifurc_steer #(
  parameter int LANES = 16,
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] IDLE_SYM = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bifurc_req,
  input  logic                     rev_en,
  input  logic [LANES*SYM_W-1:0]   phy_rx_sym,
  input  logic [LANES-1:0]         phy_rx_vld,
  input  logic [LANES*SYM_W-1:0]   pri_tx_sym,
  input  logic [LANES-1:0]         pri_tx_vld,
  input  logic [LANES*SYM_W/2-1:0] sec_tx_sym,
  input  logic [LANES/2-1:0]       sec_tx_vld,
  output logic [LANES*SYM_W-1:0]   pri_rx_sym,
  output logic [LANES-1:0]         pri_rx_vld,
  output logic [LANES*SYM_W/2-1:0] sec_rx_sym,
  output logic [LANES/2-1:0]       sec_rx_vld,
  output logic [LANES*SYM_W-1:0]   phy_tx_sym,
  output logic [LANES-1:0]         phy_tx_vld,
  output logic                     bifurc_mode,
  output logic                     sec_present
);
  localparam int HALF = LANES / 2;

  logic mode_q, pres_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= bifurc_req;
      pres_q <= 1'b0;
    end else begin
      pres_q <= mode_q;
    end
  end

  assign bifurc_mode = mode_q;
  assign sec_present = pres_q;

  for (genvar i = 0; i < HALF; i++) begin : g_lo
    localparam int WIDE = LANES - 1 - i;
    localparam int NARR = HALF - 1 - i;
    wire [31:0] src = !rev_en ? i : (mode_q ? NARR : WIDE);
    assign pri_rx_sym[i*SYM_W +: SYM_W] = phy_rx_sym[src*SYM_W +: SYM_W];
    assign pri_rx_vld[i]                = phy_rx_vld[src];
    assign phy_tx_sym[i*SYM_W +: SYM_W] = pri_tx_sym[src*SYM_W +: SYM_W];
    assign phy_tx_vld[i]                = pri_tx_vld[src];
  end

  for (genvar i = HALF; i < LANES; i++) begin : g_hi
    localparam int WIDE = LANES - 1 - i;
    localparam int J    = i - HALF;
    wire [31:0] src = rev_en ? WIDE : i;
    assign pri_rx_sym[i*SYM_W +: SYM_W] = mode_q ? IDLE_SYM : phy_rx_sym[src*SYM_W +: SYM_W];
    assign pri_rx_vld[i]                = mode_q ? 1'b0 : phy_rx_vld[src];
    assign sec_rx_sym[J*SYM_W +: SYM_W] = mode_q ? phy_rx_sym[i*SYM_W +: SYM_W] : IDLE_SYM;
    assign sec_rx_vld[J]                = mode_q & phy_rx_vld[i];
    assign phy_tx_sym[i*SYM_W +: SYM_W] = mode_q ? sec_tx_sym[J*SYM_W +: SYM_W]
                                                 : pri_tx_sym[src*SYM_W +: SYM_W];
    assign phy_tx_vld[i]                = mode_q ? sec_tx_vld[J] : pri_tx_vld[src];
  end
endmodule

// File: rtl/lane_bifurc_steer_chk.sv
module lane_bifurc_steer_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bifurc_mode,
  input logic             sec_present,
  input logic [LANES-1:0] phy_rx_vld,
  input logic [LANES-1:0] pri_rx_vld,
  input logic [LANES/2-1:0] sec_rx_vld
);
  localparam int HALF = LANES / 2;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(bifurc_mode)); // R1
  AST_SEC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    bifurc_mode |-> sec_rx_vld == phy_rx_vld[LANES-1:HALF]); // R4
  AST_SEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bifurc_mode |-> sec_rx_vld == '0); // R6
  AST_PRI_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bifurc_mode |-> pri_rx_vld[LANES-1:HALF] == '0); // R7
  AST_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bifurc_mode |-> !sec_present); // R8
  AST_PRES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> $stable(sec_present)); // R8
endmodule

bind lane_bifurc_steer lane_bifurc_steer_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bifurc_mode(bifurc_mode), .sec_present(sec_present),
  .phy_rx_vld(phy_rx_vld), .pri_rx_vld(pri_rx_vld), .sec_rx_vld(sec_rx_vld)
);

// File: tb/lane_bifurc_steer_tb.sv
module lane_bifurc_steer_tb_top;
  localparam int L = 16, W = 8, H = 8;

  logic clk = 0, rst_n = 0, bifurc_req = 0, rev_en = 0;
  logic [L*W-1:0] phy_rx_sym = '0, pri_tx_sym = '0;
  logic [L-1:0]   phy_rx_vld = '0, pri_tx_vld = '0;
  logic [H*W-1:0] sec_tx_sym = '0;
  logic [H-1:0]   sec_tx_vld = '0;
  logic [L*W-1:0] pri_rx_sym, phy_tx_sym;
  logic [L-1:0]   pri_rx_vld, phy_tx_vld;
  logic [H*W-1:0] sec_rx_sym;
  logic [H-1:0]   sec_rx_vld;
  logic bifurc_mode, sec_present;

  int errors = 0, checks = 0;
  int m_mode = 0, m_pres = 0;

  always #5 clk = ~clk;

  lane_bifurc_steer dut_i (.*);

  always @(posedge clk) begin
    if (!rst_n) begin m_mode <= bifurc_req; m_pres <= 0; end
    else m_pres <= m_mode;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input bit in_rst);
    logic [L*W-1:0] e_prs, e_pts; logic [L-1:0] e_prv, e_ptv;
    logic [H*W-1:0] e_srs; logic [H-1:0] e_srv;
    string tp;
    e_prs = '0; e_prv = '0; e_srs = '0; e_srv = '0; e_pts = '0; e_ptv = '0;
    tp = m_mode ? (rev_en ? "R5" : "R5 R7") : (rev_en ? "R3" : "R2");
    for (int i = 0; i < L; i++) begin
      int p;
      if (m_mode && i >= H) continue;
      p = !rev_en ? i : (m_mode ? H - 1 - i : L - 1 - i);
      e_prs[i*W +: W] = phy_rx_sym[p*W +: W]; e_prv[i] = phy_rx_vld[p];
      e_pts[p*W +: W] = pri_tx_sym[i*W +: W]; e_ptv[p] = pri_tx_vld[i];
    end
    if (m_mode) for (int j = 0; j < H; j++) begin
      e_srs[j*W +: W] = phy_rx_sym[(H+j)*W +: W]; e_srv[j] = phy_rx_vld[H+j];
      e_pts[(H+j)*W +: W] = sec_tx_sym[j*W +: W]; e_ptv[H+j] = sec_tx_vld[j];
    end
    if (!in_rst) begin
      chk({tp, " pri_rx_sym"}, 128'(pri_rx_sym), 128'(e_prs));
      chk({tp, " pri_rx_vld"}, 128'(pri_rx_vld), 128'(e_prv));
      chk(m_mode ? "R4 sec_rx_sym" : "R6 sec_rx_sym", 128'(sec_rx_sym), 128'(e_srs));
      chk(m_mode ? "R4 sec_rx_vld" : "R6 sec_rx_vld", 128'(sec_rx_vld), 128'(e_srv));
      chk(m_mode ? "R4 R7 phy_tx_sym" : "R6 phy_tx_sym", 128'(phy_tx_sym), 128'(e_pts));
      chk(m_mode ? "R4 R7 phy_tx_vld" : "R6 phy_tx_vld", 128'(phy_tx_vld), 128'(e_ptv));
      chk("R1 bifurc_mode", 128'(bifurc_mode), 128'(m_mode));
    end
    chk("R8 sec_present", 128'(sec_present), 128'(m_pres));
  endtask

  task automatic stim(input bit narrow);
    for (int i = 0; i < L; i++) begin
      phy_rx_sym[i*W +: W] = 8'($urandom); pri_tx_sym[i*W +: W] = 8'($urandom);
    end
    for (int j = 0; j < H; j++) sec_tx_sym[j*W +: W] = 8'($urandom);
    phy_rx_vld = 16'($urandom); pri_tx_vld = 16'($urandom); sec_tx_vld = 8'($urandom);
    if (narrow) begin phy_rx_vld = 16'h000F; pri_tx_vld = 16'h000F; end
  endtask

  task automatic phase(input bit mode, input bit rev);
    @(posedge clk); #1 rst_n = 0; bifurc_req = mode; rev_en = rev;
    repeat (3) begin @(posedge clk); #1 stim(0); @(negedge clk); compare(1); end
    @(posedge clk); #1 rst_n = 1;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #1;
      stim(c >= 30);
      if (c == 10) bifurc_req = !mode;  // R1: change after reset is ignored
      @(negedge clk); compare(0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    phase(0, 0);
    phase(0, 1);
    phase(1, 0);
    phase(1, 1);
    phase(0, 1);
    phase(1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule